// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 16-bit successive-approximation converter. Two active-low-style control inputs, a chip select and a read/convert line, are ORed into a single gate. A high-to-low transition of that gate starts a conversion. The same pair of inputs, with chip select low and read/convert high, opens the data bus for reading. The analog sampler, the capacitive DAC and the comparator sit outside. Their decision reaches the block as the single-bit input `cmp_in`.

A conversion walks the result register from the most significant bit down to the least, one bit per clock. The result is then copied into an output latch in one further cycle. The `busy` flag is low for the whole conversion and rises in the same edge that updates the latch. A byte-select input chooses whether the bus shows the result in natural order or with its two halves exchanged.

The control state machine has three states:
- ST_IDLE: `busy` is high and the block waits for a start.
- ST_CONVERT: one bit is decided per cycle.
- ST_LOAD: the result is copied into the latch.

It has these transitions:
- ST_IDLE to ST_CONVERT, on a gate falling edge, or when the gate is already low in the first idle cycle after a load.
- ST_CONVERT to ST_CONVERT, while bits remain.
- ST_CONVERT to ST_LOAD, after the least significant bit.
- ST_LOAD to ST_IDLE, always.

Top module: `sarconv_ctrl`

## Requirements
- R1: A falling edge of the gate (cs_n OR rd_cvt) while `busy` is high starts a conversion. The edge can come from rd_cvt falling while cs_n is low, or from cs_n falling while rd_cvt is low. `busy` reads low in the cycle after the edge.
- R2: `dq` is high-impedance whenever cs_n is 1 or rd_cvt is 0. It is driven whenever cs_n is 0 and rd_cvt is 1.
- R3: A gate falling edge that arrives while `busy` is low has no effect on the running conversion, on its length or on its result.
- R4: Bits are decided from bit 15 down to bit 0, one per clock. A bit is set to 1 when `cmp_in` is 1 in its decision cycle, and to 0 otherwise. The final result equals the sequence of comparator decisions, MSB first.
- R5: `busy` stays low for exactly RES_BITS+1 cycles: 16 decision cycles and one load cycle. The output latch takes the new result in the edge at which `busy` rises.
- R6: With byte_sel = 0, dq[15:0] equals result[15:0]. With byte_sel = 1, dq[15:8] = result[7:0] and dq[7:0] = result[15:8].
- R7: After reset, `busy` is 1 and the latch reads 0. The latch holds its value while `busy` stays high, whatever happens on `cmp_in`, `byte_sel` or reads.
- R8: If the gate is low when `busy` rises, a new conversion starts at once, and `busy` reads low again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_cvt | input | 1 | Read (high) / convert (low) control |
| byte_sel | input | 1 | 1 exchanges the upper and lower bus bytes |
| cmp_in | input | 1 | Comparator decision for the bit under trial |
| busy | output | 1 | Low while a conversion runs |
| dq | output | 16 | Tri-state result bus |

## Verification
The bench builds the block with RES_BITS = 16, its default. This makes the bus two full bytes, so the byte exchange of R6 shows at every bit position. It also makes a conversion 17 cycles long, which is short enough to run back-to-back and restarted conversions in full.

The bench places a pull-up on every bus line. A released bus therefore reads all ones, which no chosen result value equals, so high impedance can be told apart from driven data.

// File: rtl/sarconv_pkg.sv
package sarconv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_LOAD    = 2'd2
    } sar_state_t;

endpackage

// File: rtl/sarconv_trigger.sv
// Decodes chip select and read/convert into a start event and a bus enable.
module sarconv_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_cvt,
    output logic gate_low,
    output logic start_edge,
    output logic read_en
);

    logic gate_now;
    logic gate_q;

    assign gate_now = cs_n | rd_cvt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
        end else begin
            gate_q <= gate_now;
        end
    end

    assign gate_low   = ~gate_now;
    assign start_edge = gate_q & ~gate_now;
    assign read_en    = ~cs_n & rd_cvt;

endmodule

// File: rtl/sarconv_fsm.sv
// Sequencing: idle, bit decisions, result load.
module sarconv_fsm
    import sarconv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_edge,
    input  logic gate_low,
    input  logic last_bit,
    output logic busy,
    output logic sar_init,
    output logic sar_step,
    output logic load_res
);

    sar_state_t state_q;
    sar_state_t state_d;
    logic       done_q;
    logic       go;

    // A start is accepted only in idle; a gate still low right after a load restarts.
    assign go = start_edge | (done_q & gate_low);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_d = ST_CONVERT;
            ST_CONVERT: if (last_bit) state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_LOAD);
        end
    end

    always_comb begin
        busy     = 1'b0;
        sar_init = 1'b0;
        sar_step = 1'b0;
        load_res = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b1;
                sar_init = go;
            end
            ST_CONVERT: sar_step = 1'b1;
            ST_LOAD:    load_res = 1'b1;
            default:    busy     = 1'b1;
        endcase
    end

endmodule

// File: rtl/sarconv_sar.sv
// Successive-approximation register: trial bit set, then kept or cleared.
module sarconv_sar #(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sar_init,
    input  logic                sar_step,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] sar_val,
    output logic                last_bit
);

    localparam int IDX_W = $clog2(RES_BITS);
    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_BITS - 1);

    logic [RES_BITS-1:0] sar_q, sar_d;
    logic [IDX_W-1:0]    idx_q, idx_d;

    always_comb begin
        sar_d = sar_q;
        idx_d = idx_q;
        if (sar_init) begin
            sar_d               = '0;
            sar_d[RES_BITS-1]   = 1'b1;
            idx_d               = MSB_IDX;
        end else if (sar_step) begin
            sar_d[idx_q] = cmp_in;
            if (idx_q != '0) begin
                sar_d[idx_q - 1'b1] = 1'b1;
                idx_d               = idx_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q <= '0;
            idx_q <= '0;
        end else begin
            sar_q <= sar_d;
            idx_q <= idx_d;
        end
    end

    assign sar_val  = sar_q;
    assign last_bit = (idx_q == '0);

endmodule

// File: rtl/sarconv_outlatch.sv
// Result latch, byte ordering and tri-state bus drive.
module sarconv_outlatch #(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_res,
    input  logic [RES_BITS-1:0] sar_val,
    input  logic                byte_sel,
    input  logic                read_en,
    output logic [RES_BITS-1:0] res_o,
    output logic [RES_BITS-1:0] dq
);

    localparam int HALF = RES_BITS / 2;

    logic [RES_BITS-1:0] res_q;
    logic [RES_BITS-1:0] ordered;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (load_res) begin
            res_q <= sar_val;
        end
    end

    assign ordered = byte_sel ? {res_q[HALF-1:0], res_q[RES_BITS-1:HALF]} : res_q;
    assign dq      = read_en ? ordered : {RES_BITS{1'bz}};
    assign res_o   = res_q;

endmodule

// File: rtl/sarconv_ctrl.sv
module sarconv_ctrl #(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rd_cvt,
    input  logic                byte_sel,
    input  logic                cmp_in,
    output logic                busy,
    output logic [RES_BITS-1:0] dq
);

    logic                gate_low;
    logic                start_edge;
    logic                read_en;
    logic                last_bit;
    logic                sar_init;
    logic                sar_step;
    logic                load_res;
    logic [RES_BITS-1:0] sar_val;
    logic [RES_BITS-1:0] result_w;

    sarconv_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_cvt     (rd_cvt),
        .gate_low   (gate_low),
        .start_edge (start_edge),
        .read_en    (read_en)
    );

    sarconv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_edge (start_edge),
        .gate_low   (gate_low),
        .last_bit   (last_bit),
        .busy       (busy),
        .sar_init   (sar_init),
        .sar_step   (sar_step),
        .load_res   (load_res)
    );

    sarconv_sar #(.RES_BITS(RES_BITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .sar_init (sar_init),
        .sar_step (sar_step),
        .cmp_in   (cmp_in),
        .sar_val  (sar_val),
        .last_bit (last_bit)
    );

    sarconv_outlatch #(.RES_BITS(RES_BITS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_res (load_res),
        .sar_val  (sar_val),
        .byte_sel (byte_sel),
        .read_en  (read_en),
        .res_o    (result_w),
        .dq       (dq)
    );

endmodule

// File: rtl/sarconv_checker.sv
module sarconv_checker #(
    parameter int RES_BITS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                rd_cvt,
    input logic                busy,
    input logic [RES_BITS-1:0] result_q
);

    localparam int CNT_W = $clog2(RES_BITS + 2) + 1;

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (busy) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r1_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(cs_n | rd_cvt) && !(cs_n | rd_cvt)) |=> !busy);

    a_r3_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (low_cnt < CNT_W'(RES_BITS))) |=> !busy);

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (low_cnt == CNT_W'(RES_BITS + 1)));

    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result_q));

    a_r8_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !(cs_n | rd_cvt)) |=> !busy);

endmodule

bind sarconv_ctrl sarconv_checker #(.RES_BITS(RES_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_cvt   (rd_cvt),
    .busy     (busy),
    .result_q (result_w)
);

// File: tb/sarconv_ctrl_bench.sv
module sarconv_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RB = 16;
    localparam logic [RB-1:0] RELEASED = 16'hFFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_cvt = 1'b1;
    logic          byte_sel = 1'b0;
    logic          cmp_in = 1'b0;
    logic          busy;
    wire  [RB-1:0] dq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    for (genvar gi = 0; gi < RB; gi++) begin : g_pull
        pullup (dq[gi]);
    end

    sarconv_ctrl #(.RES_BITS(RB)) u_sarconv_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_cvt   (rd_cvt),
        .byte_sel (byte_sel),
        .cmp_in   (cmp_in),
        .busy     (busy),
        .dq       (dq)
    );

    task automatic check(input bit ok, input string req, input logic [RB-1:0] act,
                         input logic [RB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at the negedge right after the start edge.
    task automatic conv_body(input logic [RB-1:0] tgt, input int glitch, input bit hold_low);
        check(busy == 1'b0, "R1 busy after start", {15'd0, busy}, 16'd0);
        for (int i = RB - 1; i >= 0; i--) begin
            cmp_in = tgt[i];
            if (!hold_low) rd_cvt = (i == glitch) ? 1'b0 : 1'b1;
            #1;
            if (i == glitch)
                check(dq === RELEASED, "R2 bus released with rd_cvt low", dq, RELEASED);
            if (hold_low && i == RB / 2)
                check(dq === RELEASED, "R2 bus released while converting", dq, RELEASED);
            tick();
        end
        if (!hold_low) rd_cvt = 1'b1;
        check(busy == 1'b0, "R5 busy low in load cycle", {15'd0, busy}, 16'd0);
        tick();
        check(busy == 1'b1, "R5 busy high after load", {15'd0, busy}, 16'd1);
    endtask

    task automatic read_result(input logic [RB-1:0] tgt, input string req);
        cs_n = 1'b0;
        rd_cvt = 1'b1;
        byte_sel = 1'b0;
        #1;
        check(dq === tgt, req, dq, tgt);
        byte_sel = 1'b1;
        #1;
        check(dq === {tgt[7:0], tgt[15:8]}, "R6 swapped order", dq, {tgt[7:0], tgt[15:8]});
        byte_sel = 1'b0;
        #1;
    endtask

    task automatic start_by_rc();
        cs_n = 1'b0;
        rd_cvt = 1'b1;
        tick();
        rd_cvt = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        check(busy == 1'b1, "R7 busy after reset", {15'd0, busy}, 16'd1);
        read_result(16'h0000, "R7 latch zero after reset");
        cs_n = 1'b1;
        #1;
        check(dq === RELEASED, "R2 released with cs_n high", dq, RELEASED);
        tick();
    endtask

    task automatic t_conv_rc();
        start_by_rc();
        conv_body(16'hA5C3, -1, 1'b0);
        read_result(16'hA5C3, "R4 result via rd_cvt start");
        cs_n = 1'b1;
        tick();
    endtask

    task automatic t_conv_cs();
        cs_n = 1'b1;
        rd_cvt = 1'b0;
        #1;
        check(dq === RELEASED, "R2 released cs_n high rd_cvt low", dq, RELEASED);
        tick();
        check(busy == 1'b1, "R1 no start without gate edge", {15'd0, busy}, 16'd1);
        cs_n = 1'b0;
        tick();
        cs_n = 1'b1;
        conv_body(16'h3C5A, -1, 1'b0);
        read_result(16'h3C5A, "R4 result via cs_n start");
        cs_n = 1'b1;
        tick();
    endtask

    task automatic t_ignore();
        start_by_rc();
        conv_body(16'h0F81, 9, 1'b0);
        read_result(16'h0F81, "R3 mid-conversion edge ignored");
        cs_n = 1'b1;
        tick();
    endtask

    task automatic t_restart();
        start_by_rc();
        conv_body(16'h1234, -1, 1'b1);
        tick();
        check(busy == 1'b0, "R8 immediate restart", {15'd0, busy}, 16'd0);
        conv_body(16'h6E09, -1, 1'b0);
        read_result(16'h6E09, "R8 restarted result");
    endtask

    task automatic t_hold();
        for (int k = 0; k < 12; k++) begin
            cs_n = 1'b1;
            cmp_in = k[0];
            byte_sel = k[1];
            tick();
            check(busy == 1'b1, "R7 stays idle", {15'd0, busy}, 16'd1);
        end
        read_result(16'h6E09, "R7 latch held");
        cs_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_conv_rc();
        t_conv_cs();
        t_ignore();
        t_restart();
        t_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule